// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This unit connects a 32-bit register-based core to a word-addressed data memory that answers in one cycle. Each cycle the core can present one request: a six-bit opcode, a base register value, a raw 16-bit offset and a store value. The unit sign-extends the offset and adds it to the base. It then sends memory the word address, a read strobe or four per-byte write enables, and store data already placed in the correct byte lanes.

Only four operations are supported: byte load, word load, byte store and word store. Bytes within a word use big-endian order, so the byte at offset 0 sits in the most significant lane. Word accesses must be aligned. A misaligned word access is flagged and touches nothing. Read data comes back in the cycle after the request. The unit then returns either the whole word or the addressed byte sign-extended to 32 bits, together with a write-back request for the core.

Top module: `be_lane_lsu`

## Requirements
- R1: The effective address is the base value plus the sign-extended 16-bit offset, modulo 2^32. For every supported opcode, memAddr equals that address with its two lowest bits dropped.
- R2: Byte store (opcode 0x28) writes the low store byte to all four lanes of memWdata. Exactly one write enable is raised: offset 0 raises memWe[3] (bits 31:24) and offset 3 raises memWe[0] (bits 7:0), where memWe[i] guards bits 8i+7:8i.
- R3: Word store (opcode 0x2B) with an aligned address raises all four write enables and drives memWdata with the store value unchanged.
- R4: A word load or word store whose address bits 1:0 are not zero raises misalign in the same cycle. It raises no write enable and no read strobe, and wbEn stays low in the next cycle. Byte accesses never raise misalign.
- R5: Byte load (opcode 0x20) raises memRd in the request cycle. One cycle later wbEn is high and wbData holds the addressed byte, sign-extended from its bit 7. The byte at address offset k is taken from memRdata bits 31-8k down to 24-8k.
- R6: Aligned word load (opcode 0x23) raises memRd in the request cycle. One cycle later wbEn is high and wbData equals memRdata.
- R7: Nothing is acted on when reqValid is low or the opcode is not one of the four above. In that case memWe is zero, memRd and misalign are low, and wbEn is low in the next cycle. Stores also leave wbEn low.
- R8: While rstN is low, and in the first cycle after it rises, wbEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented this cycle |
| opcode | input | 6 | Operation code |
| baseVal | input | 32 | Base register value |
| offset | input | 16 | Signed address offset |
| storeData | input | 32 | Data register value for stores |
| memAddr | output | 30 | Word address to memory |
| memWe | output | 4 | Per-byte write enables, bit i guards bits 8i+7:8i |
| memWdata | output | 32 | Lane-steered store data |
| memRd | output | 1 | Read strobe |
| memRdata | input | 32 | Word returned by memory one cycle after memRd |
| misalign | output | 1 | Misaligned word access in this cycle |
| wbEn | output | 1 | Register write-back request |
| wbData | output | 32 | Write-back value |

## Verification
Address, write enables, store data, read strobe and misalign are all combinational from the request. The bench therefore checks them in the request cycle, shortly after the falling edge on which that request was driven. wbEn and wbData are due one rising edge later. The bench applies the memory word just after that edge and samples both outputs a moment afterwards, so each response is paired with the request that caused it. Requests are separated by an idle half cycle, which keeps every response window clear of the next request.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  parameter logic [5:0] OP_LD_BYTE = 6'h20;
  parameter logic [5:0] OP_LD_WORD = 6'h23;
  parameter logic [5:0] OP_ST_BYTE = 6'h28;
  parameter logic [5:0] OP_ST_WORD = 6'h2b;

  // strobes from control to datapath; at most one of the four access bits is set
  typedef struct packed {
    logic rdByte;
    logic rdWord;
    logic wrByte;
    logic wrWord;
    logic misalign;
  } lsu_strobe_t;

endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  logic              reqValid,
  input  logic [5:0]        opcode,
  input  logic [LANE_W-1:0] addrLow,
  output lsu_strobe_t       strb
);

  logic isLdByte, isLdWord, isStByte, isStWord, aligned;

  always_comb begin
    isLdByte = reqValid && (opcode == OP_LD_BYTE);
    isLdWord = reqValid && (opcode == OP_LD_WORD);
    isStByte = reqValid && (opcode == OP_ST_BYTE);
    isStWord = reqValid && (opcode == OP_ST_WORD);
    aligned  = (addrLow == '0);

    strb.rdByte   = isLdByte;
    strb.rdWord   = isLdWord && aligned;
    strb.wrByte   = isStByte;
    strb.wrWord   = isStWord && aligned;
    strb.misalign = (isLdWord || isStWord) && !aligned;
  end

endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int WADR_W = DATA_W - LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsu_strobe_t       strb,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [LANE_W-1:0] addrLow,
  output logic [WADR_W-1:0] memAddr,
  output logic [LANES-1:0]  memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              memRd,
  output logic              wbEn,
  output logic [DATA_W-1:0] wbData
);

  logic [DATA_W-1:0] effAddr;
  logic [LANE_W-1:0] physLane;
  logic              rspValid, rspByte;
  logic [LANE_W-1:0] rspLane;
  logic [7:0]        rdLanes [LANES];
  logic [7:0]        selByte;

  // address: base + sign-extended offset, big-endian lane mapping
  always_comb begin
    effAddr  = baseVal + {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};
    addrLow  = effAddr[LANE_W-1:0];
    memAddr  = effAddr[DATA_W-1:LANE_W];
    physLane = LANE_W'(LANES-1) - addrLow;
    memRd    = strb.rdByte || strb.rdWord;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign memWe[g] = strb.wrWord || (strb.wrByte && (physLane == LANE_W'(g)));
    assign memWdata[8*g +: 8] = strb.wrWord ? storeData[8*g +: 8] : storeData[7:0];
    assign rdLanes[g] = memRdata[8*g +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspByte  <= 1'b0;
      rspLane  <= '0;
    end else begin
      rspValid <= memRd;
      rspByte  <= strb.rdByte;
      rspLane  <= physLane;
    end
  end

  always_comb begin
    selByte = rdLanes[rspLane];
    wbEn    = rspValid;
    wbData  = rspByte ? {{(DATA_W-8){selByte[7]}}, selByte} : memRdata;
  end

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && (memWe != '0)));

  // R4
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.misalign |-> (memWe == '0) && !memRd);

  // R4
  misalign_no_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.misalign |=> !wbEn);

  // R5
  wb_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> $past(memRd));

  // R2
  byte_we_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrByte |-> $onehot(memWe));

endmodule

// File: rtl/be_lane_lsu.sv
module be_lane_lsu
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int WADR_W = DATA_W - LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [5:0]        opcode,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] storeData,
  output logic [WADR_W-1:0] memAddr,
  output logic [LANES-1:0]  memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              memRd,
  input  logic [DATA_W-1:0] memRdata,
  output logic              misalign,
  output logic              wbEn,
  output logic [DATA_W-1:0] wbData
);

  lsu_strobe_t       strb;
  logic [LANE_W-1:0] addrLow;

  lsu_ctrl #(.LANE_W(LANE_W)) ctrl_i (
    .reqValid (reqValid),
    .opcode   (opcode),
    .addrLow  (addrLow),
    .strb     (strb)
  );

  lsu_datapath #(.DATA_W(DATA_W), .OFF_W(OFF_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .baseVal   (baseVal),
    .offset    (offset),
    .storeData (storeData),
    .memRdata  (memRdata),
    .addrLow   (addrLow),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memWdata  (memWdata),
    .memRd     (memRd),
    .wbEn      (wbEn),
    .wbData    (wbData)
  );

  assign misalign = strb.misalign;

  // R8
  reset_wb_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !wbEn);

  // R4
  byte_no_misalign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (opcode == OP_LD_BYTE || opcode == OP_ST_BYTE)) |-> !misalign);

endmodule

// File: tb/be_lane_lsu_tb.sv
module be_lane_lsu_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [5:0]  opcode;
  logic [31:0] baseVal, storeData, memRdata, memWdata, wbData;
  logic [15:0] offset;
  logic [29:0] memAddr;
  logic [3:0]  memWe;
  logic        memRd, misalign, wbEn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  be_lane_lsu dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opcode(opcode),
    .baseVal(baseVal), .offset(offset), .storeData(storeData),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRd(memRd),
    .memRdata(memRdata), .misalign(misalign), .wbEn(wbEn), .wbData(wbData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit isSupported(input logic [5:0] op);
    return op == 6'h20 || op == 6'h23 || op == 6'h28 || op == 6'h2b;
  endfunction

  function automatic logic [31:0] eaOf(input logic [31:0] b, input logic [15:0] o);
    return b + {{16{o[15]}}, o};
  endfunction

  task automatic runOp(input logic [5:0] op, input logic [31:0] b, input logic [15:0] o,
                       input logic [31:0] sd, input logic [31:0] rd);
    logic [31:0] ea;
    logic [1:0]  k;
    logic        isWord, mis, expRd, expWb;
    logic [3:0]  expWe;
    logic [7:0]  bt;
    ea     = eaOf(b, o);
    k      = ea[1:0];
    isWord = (op == 6'h23 || op == 6'h2b);
    mis    = isWord && (k != 2'd0);
    expRd  = (op == 6'h20) || (op == 6'h23 && !mis);
    expWb  = expRd;
    expWe  = 4'h0;
    if (op == 6'h28) expWe = 4'b1000 >> k;
    if (op == 6'h2b && !mis) expWe = 4'hF;

    @(negedge clk);
    reqValid = 1'b1; opcode = op; baseVal = b; offset = o; storeData = sd;
    #1;
    if (isSupported(op)) check("R1 memAddr", {2'b0, memAddr}, {2'b0, ea[31:2]});
    check(mis ? "R4 memWe" : (op == 6'h28 ? "R2 memWe" : (op == 6'h2b ? "R3 memWe" : "R7 memWe")),
          {28'b0, memWe}, {28'b0, expWe});
    check(mis ? "R4 misalign" : "R7 misalign", {31'b0, misalign}, {31'b0, mis});
    check(op == 6'h20 ? "R5 memRd" : (op == 6'h23 ? "R6 memRd" : "R7 memRd"),
          {31'b0, memRd}, {31'b0, expRd});
    if (op == 6'h28) check("R2 memWdata", memWdata, {4{sd[7:0]}});
    if (op == 6'h2b && !mis) check("R3 memWdata", memWdata, sd);

    @(posedge clk);
    #1;
    reqValid = 1'b0; opcode = 6'h3f; memRdata = rd;
    #1;
    check(mis ? "R4 wbEn" : (expWb ? "R5/R6 wbEn" : "R7 wbEn"), {31'b0, wbEn}, {31'b0, expWb});
    if (op == 6'h20) begin
      bt = rd[31 - 8*k -: 8];
      check("R5 wbData", wbData, {{24{bt[7]}}, bt});
    end
    if (op == 6'h23 && !mis) check("R6 wbData", wbData, rd);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rs;
    logic [5:0]  op;
    logic [31:0] b, sd, rd;
    logic [15:0] o;
    rs = $urandom(32'd4410);
    rstN = 1'b0; reqValid = 1'b0; opcode = 6'h00;
    baseVal = '0; offset = '0; storeData = '0; memRdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 wbEn in reset", {31'b0, wbEn}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R8 wbEn after reset", {31'b0, wbEn}, 32'd0);
    check("R7 idle memWe", {28'b0, memWe}, 32'd0);

    // byte loads on every lane, mixed signs
    for (int k = 0; k < 4; k++) runOp(6'h20, 32'h0000_1000, 16'(k), '0, 32'h807F_01FE);
    // byte stores on every lane
    for (int k = 0; k < 4; k++) runOp(6'h28, 32'h0000_2000 + 32'(k), 16'h0, 32'hDEAD_BEA5, '0);
    runOp(6'h23, 32'h0000_0100, 16'hFFFC, '0, 32'h1234_5678);   // negative offset
    runOp(6'h2b, 32'h0000_0100, 16'h0008, 32'hCAFE_F00D, '0);
    runOp(6'h23, 32'h0000_0100, 16'h0002, '0, 32'h1111_1111);   // misaligned load
    runOp(6'h2b, 32'h0000_0101, 16'h0000, 32'h2222_2222, '0);   // misaligned store
    runOp(6'h20, 32'hFFFF_FFFE, 16'h0003, '0, 32'hAA_BB_CC_DD); // address wraps to 1
    runOp(6'h21, 32'h0000_0300, 16'h0000, 32'h5555_5555, 32'h9);// unsupported

    for (int i = 0; i < 600; i++) begin
      case ($urandom_range(0, 4))
        0: op = 6'h20;
        1: op = 6'h23;
        2: op = 6'h28;
        3: op = 6'h2b;
        default: begin
          op = 6'($urandom);
          if (isSupported(op)) op = 6'h3f;
        end
      endcase
      b = $urandom; o = 16'($urandom); sd = $urandom; rd = $urandom;
      if ($urandom_range(0, 3) != 0) b = b - {30'b0, eaOf(b, o) & 32'h3};
      runOp(op, b, o, sd, rd);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule